// File: doc/BRIEF.md
# Coin-Operated Vending Controller

This block is the control core of a soda vending machine. It takes three coin inputs: a nickel worth 5, a dime worth 10 and a quarter worth 25. Each coin input is a pulse one clock cycle wide, made upstream from the rising edge of a key press, so a held key counts once. The block adds each coin to a running total. It shows that total on two binary-coded-decimal digits, a tens digit and a units digit.

When a coin brings the total to the price or above, the machine enters its vending state. It raises the dispense output there. It also raises the change output if the total went past the price. A level input reports that a coin key is still held down. The machine stays in the vending state while that level is high and ignores further coins. When the level drops, the total returns to zero and the machine goes back to collecting.

The price is a parameter with a default of 30. Any excess over the price is returned and is not carried into the next sale. The block has no debouncing, no edge detection and no display driver.

Top module: `vend_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the total, so both digits read 0 and both dispense and change read 0 on the cycle after reset.
- R2: While collecting, a pulse on nickel, dime or quarter adds 5, 10 or 25 to the total, and the digits show the new total one cycle after the pulse cycle.
- R3: When several coin pulses arrive in the same cycle, only one coin is counted. Quarter wins over dime, and dime wins over nickel.
- R4: A coin that brings the total to exactly the price raises dispense one cycle after the pulse, with change low.
- R5: A coin that brings the total above the price raises dispense and change together one cycle after the pulse. Change is never high without dispense.
- R6: While dispense is high and the any-key input is high, dispense, change and both digits hold their values.
- R7: Coin pulses that arrive while dispense is high do not change the displayed total.
- R8: In the first cycle with dispense high and any-key low, the next cycle has dispense low, change low and a total of zero.
- R9: The tens digit equals the total divided by 10, the units digit equals the total modulo 10, and neither digit exceeds 9 (largest reachable total: price minus 5 plus 25, which is 50 at the default price).
- R10: While collecting with no coin pulse, the total stays as it is and dispense stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| coin_nickel | input | 1 | One-cycle pulse, 5 inserted |
| coin_dime | input | 1 | One-cycle pulse, 10 inserted |
| coin_quarter | input | 1 | One-cycle pulse, 25 inserted |
| key_held | input | 1 | High while any coin key is physically pressed |
| dispense | output | 1 | High in the vending state |
| give_change | output | 1 | High in the vending state when the total exceeds the price |
| digit_tens | output | 4 | Tens digit of the total, BCD |
| digit_ones | output | 4 | Units digit of the total, BCD |

## Verification
Two conditions are hard to reach from the ports. One is a coin pulse that lands inside a vending interval. The other is a vending interval in which the key is already released. The stimulus reaches the first by keeping key_held high after the coin that triggers the sale, then pulsing all three coins while the bench watches the digits stay frozen. It reaches the second by sending the triggering coin with key_held low, so the vending state lasts exactly one cycle. Simultaneous pulses are driven both from an empty total and from a partial total, to test the priority order.

// File: rtl/vend_pkg.sv
package vend_pkg;

    typedef enum logic [0:0] {
        ST_COLLECT = 1'b0,
        ST_VEND    = 1'b1
    } vend_state_e;

    localparam int DIGIT_W = 4;

endpackage

// File: rtl/vend_coin_sel.sv
// Chooses a single coin out of possibly coincident pulses and reports its value.
module vend_coin_sel #(
    parameter int VAL_W   = 6,
    parameter int NICKEL  = 5,
    parameter int DIME    = 10,
    parameter int QUARTER = 25
) (
    input  logic             nickel_i,
    input  logic             dime_i,
    input  logic             quarter_i,
    output logic             valid_o,
    output logic [VAL_W-1:0] value_o
);

    localparam logic [VAL_W-1:0] V_NICKEL  = VAL_W'(NICKEL);
    localparam logic [VAL_W-1:0] V_DIME    = VAL_W'(DIME);
    localparam logic [VAL_W-1:0] V_QUARTER = VAL_W'(QUARTER);

    always_comb begin
        valid_o = nickel_i | dime_i | quarter_i;
        if (quarter_i) begin
            value_o = V_QUARTER;
        end else if (dime_i) begin
            value_o = V_DIME;
        end else if (nickel_i) begin
            value_o = V_NICKEL;
        end else begin
            value_o = '0;
        end
    end

endmodule

// File: rtl/vend_bcd.sv
// Shift-and-add-3 conversion of a small binary value into two BCD digits.
module vend_bcd #(
    parameter int BIN_W = 6
) (
    input  logic [BIN_W-1:0] bin_i,
    output logic [3:0]       tens_o,
    output logic [3:0]       ones_o
);

    logic [7:0] acc;

    always_comb begin
        acc = '0;
        for (int i = BIN_W - 1; i >= 0; i--) begin
            if (acc[3:0] >= 4'd5) acc[3:0] = acc[3:0] + 4'd3;
            if (acc[7:4] >= 4'd5) acc[7:4] = acc[7:4] + 4'd3;
            acc = {acc[6:0], bin_i[i]};
        end
        tens_o = acc[7:4];
        ones_o = acc[3:0];
    end

endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl #(
    parameter int PRICE   = 30,
    parameter int NICKEL  = 5,
    parameter int DIME    = 10,
    parameter int QUARTER = 25
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       coin_nickel,
    input  logic       coin_dime,
    input  logic       coin_quarter,
    input  logic       key_held,
    output logic       dispense,
    output logic       give_change,
    output logic [3:0] digit_tens,
    output logic [3:0] digit_ones
);
    import vend_pkg::*;

    localparam int MAX_TOTAL = PRICE - NICKEL + QUARTER;
    localparam int TOT_W     = $clog2(MAX_TOTAL + 1);
    localparam int SUM_W     = TOT_W + 1;
    localparam logic [SUM_W-1:0] PRICE_V = SUM_W'(PRICE);

    typedef struct packed {
        vend_state_e      state;
        logic [TOT_W-1:0] total;
        logic             disp;
        logic             chg;
    } regs_t;

    localparam regs_t REGS_RST = '{state: ST_COLLECT, total: '0, disp: 1'b0, chg: 1'b0};

    regs_t            r_d, r_q;
    logic             coin_vld;
    logic [TOT_W-1:0] coin_val;
    logic [SUM_W-1:0] sum;

    vend_coin_sel #(
        .VAL_W  (TOT_W),
        .NICKEL (NICKEL),
        .DIME   (DIME),
        .QUARTER(QUARTER)
    ) u_sel (
        .nickel_i (coin_nickel),
        .dime_i   (coin_dime),
        .quarter_i(coin_quarter),
        .valid_o  (coin_vld),
        .value_o  (coin_val)
    );

    assign sum = {1'b0, r_q.total} + {1'b0, coin_val};

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_COLLECT: begin
                if (coin_vld) begin
                    r_d.total = sum[TOT_W-1:0];
                    if (sum >= PRICE_V) begin
                        r_d.state = ST_VEND;
                        r_d.disp  = 1'b1;
                        r_d.chg   = (sum > PRICE_V);
                    end
                end
            end
            ST_VEND: begin
                if (!key_held) begin
                    r_d = REGS_RST;
                end
            end
            default: r_d = REGS_RST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= REGS_RST;
        end else begin
            r_q <= r_d;
        end
    end

    vend_bcd #(
        .BIN_W(TOT_W)
    ) u_bcd (
        .bin_i (r_q.total),
        .tens_o(digit_tens),
        .ones_o(digit_ones)
    );

    assign dispense    = r_q.disp;
    assign give_change = r_q.chg;

endmodule

// File: rtl/vend_ctrl_chk.sv
module vend_ctrl_chk #(
    parameter int PRICE = 30
) (
    input logic       clk,
    input logic       rst,
    input logic       coin_nickel,
    input logic       coin_dime,
    input logic       coin_quarter,
    input logic       key_held,
    input logic       dispense,
    input logic       give_change,
    input logic [3:0] digit_tens,
    input logic [3:0] digit_ones
);

    int shown;
    assign shown = int'(digit_tens) * 10 + int'(digit_ones);

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!dispense && !give_change && digit_tens == 4'd0 && digit_ones == 4'd0)); // R1

    AST_RISE_AT_PRICE: assert property (@(posedge clk) disable iff (rst)
        $rose(dispense) |-> (shown >= PRICE)); // R4

    AST_CHANGE_NEEDS_DISP: assert property (@(posedge clk) disable iff (rst)
        give_change |-> dispense); // R5

    AST_HOLD_WHILE_KEY: assert property (@(posedge clk) disable iff (rst)
        (dispense && key_held) |=> (dispense && $stable(give_change))); // R6

    AST_NO_COIN_IN_VEND: assert property (@(posedge clk) disable iff (rst)
        (dispense && key_held) |=> ($stable(digit_tens) && $stable(digit_ones))); // R7

    AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (dispense && !key_held) |=> (!dispense && !give_change && shown == 0)); // R8

    AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (rst)
        (digit_tens <= 4'd9 && digit_ones <= 4'd9)); // R9

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!dispense && !coin_nickel && !coin_dime && !coin_quarter)
        |=> (!dispense && $stable(digit_tens) && $stable(digit_ones))); // R10

endmodule

bind vend_ctrl vend_ctrl_chk #(.PRICE(PRICE)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .coin_nickel (coin_nickel),
    .coin_dime   (coin_dime),
    .coin_quarter(coin_quarter),
    .key_held    (key_held),
    .dispense    (dispense),
    .give_change (give_change),
    .digit_tens  (digit_tens),
    .digit_ones  (digit_ones)
);

// File: tb/vend_ctrl_test.sv
`timescale 1ns/1ps
module vend_ctrl_test;

    localparam int PRICE = 30;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       coin_nickel = 1'b0;
    logic       coin_dime = 1'b0;
    logic       coin_quarter = 1'b0;
    logic       key_held = 1'b0;
    logic       dispense;
    logic       give_change;
    logic [3:0] digit_tens;
    logic [3:0] digit_ones;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    vend_ctrl #(.PRICE(PRICE)) uut (
        .clk         (clk),
        .rst         (rst),
        .coin_nickel (coin_nickel),
        .coin_dime   (coin_dime),
        .coin_quarter(coin_quarter),
        .key_held    (key_held),
        .dispense    (dispense),
        .give_change (give_change),
        .digit_tens  (digit_tens),
        .digit_ones  (digit_ones)
    );

    function automatic int shown();
        return int'(digit_tens) * 10 + int'(digit_ones);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Outputs after the task are those following the pulse edge.
    task automatic coins(input bit n, input bit d, input bit q, input bit hold);
        @(negedge clk);
        coin_nickel = n; coin_dime = d; coin_quarter = q; key_held = hold;
        @(negedge clk);
        coin_nickel = 1'b0; coin_dime = 1'b0; coin_quarter = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; key_held = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 total", shown(), 0);
        chk("R1 dispense", int'(dispense), 0);
        chk("R1 change", int'(give_change), 0);
    endtask

    task automatic t_values();
        do_reset();
        coins(1, 0, 0, 1);
        chk("R2 nickel", shown(), 5);
        coins(0, 1, 0, 1);
        chk("R2 dime", shown(), 15);
        chk("R9 tens", int'(digit_tens), 1);
        chk("R9 ones", int'(digit_ones), 5);
        for (int i = 0; i < 4; i++) @(negedge clk);
        chk("R10 hold", shown(), 15);
        chk("R10 no dispense", int'(dispense), 0);
        do_reset();
        coins(0, 0, 1, 1);
        chk("R2 quarter", shown(), 25);
    endtask

    task automatic t_priority();
        do_reset();
        coins(1, 1, 1, 1);
        chk("R3 all three", shown(), 25);
        do_reset();
        coins(1, 1, 0, 1);
        chk("R3 dime over nickel", shown(), 10);
        coins(1, 0, 1, 1);
        chk("R3 quarter over nickel", shown(), 35);
        chk("R5 dispense", int'(dispense), 1);
        chk("R5 change", int'(give_change), 1);
    endtask

    task automatic t_exact();
        do_reset();
        coins(0, 0, 1, 0);
        coins(1, 0, 0, 1);
        chk("R4 dispense", int'(dispense), 1);
        chk("R4 change", int'(give_change), 0);
        chk("R4 total", shown(), 30);
        for (int i = 0; i < 3; i++) @(negedge clk);
        chk("R6 still dispensing", int'(dispense), 1);
        chk("R6 total held", shown(), 30);
        coins(0, 0, 1, 1);
        coins(1, 1, 1, 1);
        chk("R7 coin ignored", shown(), 30);
        chk("R7 change unchanged", int'(give_change), 0);
        @(negedge clk);
        key_held = 1'b0;
        @(negedge clk);
        chk("R8 dispense off", int'(dispense), 0);
        chk("R8 total zero", shown(), 0);
    endtask

    task automatic t_over();
        do_reset();
        coins(0, 0, 1, 0);
        coins(0, 0, 1, 1);
        chk("R5 dispense", int'(dispense), 1);
        chk("R5 change", int'(give_change), 1);
        chk("R9 tens at max", int'(digit_tens), 5);
        chk("R9 ones at max", int'(digit_ones), 0);
        @(negedge clk);
        key_held = 1'b0;
        @(negedge clk);
        chk("R8 change off", int'(give_change), 0);
        chk("R8 total zero", shown(), 0);
    endtask

    task automatic t_short_vend();
        do_reset();
        coins(0, 0, 1, 0);
        coins(0, 1, 0, 0);
        chk("R5 short dispense", int'(dispense), 1);
        chk("R9 ones at 35", int'(digit_ones), 5);
        @(negedge clk);
        chk("R8 one-cycle vend", int'(dispense), 0);
        chk("R8 cleared", shown(), 0);
        coins(0, 1, 0, 0);
        chk("R2 new sale", shown(), 10);
    endtask

    initial begin
        t_reset();
        t_values();
        t_priority();
        t_exact();
        t_over();
        t_short_vend();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule